// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Converter

This block sits between a set of wakeup-capable interrupt pins and a downstream interrupt controller that only understands active-high levels and rising edges. Each pin has an enable bit and a 3-bit type code. Sources that are active-low or falling-edge are inverted on the way through, so they arrive as active-high or rising-edge signals. A pin set to dual-edge produces a one-cycle high pulse on every transition of its input. A pin whose enable is clear drives a constant low.

Software reaches the settings through a single-cycle register port with address, write data, write enable and read data. Enable bits are packed 32 to a word. Each pin has its own type word. Every stored value reads back exactly as written, so software can poll until the readback matches.

For each pin, the settings pick one of four output paths. PATH_OFF is taken when the enable is clear. PATH_TOGGLE is taken for code 7. PATH_PASS is taken when bit 2 of the code is set. PATH_INVERT is taken when bit 2 is clear. The path changes only when a register write updates the stored enable or code. That write takes effect at the clock edge that accepts it, and the output follows the new path from the next cycle.

Top module: `wake_irq_conv`

## Requirements
- R1: After reset every enable bit reads 0, every type word reads 4, and every `pin_out` bit is 0 whatever `pin_in` holds.
- R2: The enable bit of pin p is held in the word at byte address 0x10 + 4*(p/32), at bit position p mod 32. A read of that word returns the stored bits. Bit positions for pins at or above NUM_PINS read 0.
- R3: The type word of pin p is at byte address 0x110 + 4*p. A write stores bits [2:0]. A read returns those three bits with bits [31:3] zero.
- R4: A read of any address that is not 4-byte aligned, or that lies outside both ranges above, returns 0. A write to such an address changes no stored bit and no output.
- R5: While a pin's enable bit is 0, its `pin_out` bit is 0.
- R6: An enabled pin with type 4 (active-high level) or type 6 (rising edge) drives `pin_out` equal to `pin_in` in the same cycle.
- R7: An enabled pin with type 0 (active-low level) or type 2 (falling edge) drives `pin_out` equal to the inverse of `pin_in` in the same cycle.
- R8: An enabled pin with type 7 (dual edge) drives `pin_out` high in exactly those cycles where `pin_in` differs from its value in the previous cycle. The output is low while the input is stable.
- R9: A register write changes stored state at the clock edge that accepts it. In the cycle of the write, both `pin_out` and `reg_rdata` reflect the old settings. From the following cycle they reflect the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; pins are assumed already synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pin_in | input | NUM_PINS | Raw interrupt pin levels |
| pin_out | output | NUM_PINS | Conditioned active-high / rising-edge outputs |

## Verification
A register write can land in the same cycle as a change on the pin it reconfigures. Two cases are tested this way. In the first, a dual-edge pin is switched to level mode on the same edge its input falls. In the second, an inverting pin is disabled in a cycle where its input would drive the output high. A read of a type word is also issued in the same cycle as a write to it. The expected values are taken from a model of the settings held before the write: a pulse, a high output, and the old readback. In the next cycle the check expects the level value, a low output, and the new code.

// File: rtl/wic_pkg.sv
package wic_pkg;

    // Byte base addresses of the two register ranges
    localparam int EN_BASE  = 32'h010;
    localparam int CFG_BASE = 32'h110;

    // Type codes held in a pin's 3-bit word
    localparam logic [2:0] TYPE_LVL_LOW  = 3'd0;
    localparam logic [2:0] TYPE_FALL     = 3'd2;
    localparam logic [2:0] TYPE_LVL_HIGH = 3'd4;
    localparam logic [2:0] TYPE_RISE     = 3'd6;
    localparam logic [2:0] TYPE_BOTH     = 3'd7;

    // Output path chosen per pin
    typedef enum logic [1:0] {
        PATH_OFF    = 2'd0,
        PATH_PASS   = 2'd1,
        PATH_INVERT = 2'd2,
        PATH_TOGGLE = 2'd3
    } path_e;

endpackage

// File: rtl/wic_regfile.sv
module wic_regfile
    import wic_pkg::*;
#(
    parameter int NUM_PINS = 126,
    parameter int ADDR_W   = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic                         reg_we,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    output logic [NUM_PINS-1:0]          en_o,
    output logic [NUM_PINS-1:0][2:0]     cfg_o
);

    localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
    localparam int IDX_W     = ADDR_W - 2;
    localparam int PIDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
    localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_BASE + 4 * NUM_WORDS);
    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 4 * NUM_PINS);

    logic [NUM_PINS-1:0]      en_q;
    logic [NUM_PINS-1:0][2:0] cfg_q;

    logic              aligned;
    logic              en_hit;
    logic              cfg_hit;
    logic [ADDR_W-1:0] en_off;
    logic [ADDR_W-1:0] cfg_off;
    logic [IDX_W-1:0]  en_idx;
    logic [IDX_W-1:0]  cfg_idx;
    logic [PIDX_W-1:0] cfg_sel;

    // Address decode
    always_comb begin
        aligned = (reg_addr[1:0] == 2'b00);
        en_hit  = aligned && (reg_addr >= EN_LO)  && (reg_addr < EN_HI);
        cfg_hit = aligned && (reg_addr >= CFG_LO) && (reg_addr < CFG_HI);
        en_off  = reg_addr - EN_LO;
        cfg_off = reg_addr - CFG_LO;
        en_idx  = en_off[ADDR_W-1:2];
        cfg_idx = cfg_off[ADDR_W-1:2];
        cfg_sel = cfg_idx[PIDX_W-1:0];
    end

    // Storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int p = 0; p < NUM_PINS; p++) begin
                cfg_q[p] <= TYPE_LVL_HIGH;
            end
        end else if (reg_we) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (en_hit && (int'(en_idx) == p / 32)) begin
                    en_q[p] <= reg_wdata[p % 32];
                end
                if (cfg_hit && (int'(cfg_idx) == p)) begin
                    cfg_q[p] <= reg_wdata[2:0];
                end
            end
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (en_hit) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (int'(en_idx) == p / 32) begin
                    reg_rdata[p % 32] = en_q[p];
                end
            end
        end else if (cfg_hit) begin
            reg_rdata[2:0] = cfg_q[cfg_sel];
        end
    end

    assign en_o  = en_q;
    assign cfg_o = cfg_q;

    // R3: a stored type code equals the low bits of the last write
    a_r3_cfg_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && cfg_hit) |=> (cfg_q[$past(cfg_sel)] == $past(reg_wdata[2:0])));

    // R4: writes outside both ranges leave every stored bit alone
    a_r4_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !en_hit && !cfg_hit) |=> ($stable(en_q) && $stable(cfg_q)));

    // R2: a read never returns two ranges at once
    a_r2_single_range: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_hit && cfg_hit));

endmodule

// File: rtl/wic_pin_cond.sv
module wic_pin_cond
    import wic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [2:0] cfg_i,
    input  logic       pin_i,
    output logic       out_o
);

    logic  prev_q;
    logic  live_q;
    path_e path;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            live_q <= 1'b0;
        end else begin
            prev_q <= pin_i;
            live_q <= 1'b1;
        end
    end

    // Path selection
    always_comb begin
        if (!en_i) begin
            path = PATH_OFF;
        end else if (cfg_i == TYPE_BOTH) begin
            path = PATH_TOGGLE;
        end else if (cfg_i[2]) begin
            path = PATH_PASS;
        end else begin
            path = PATH_INVERT;
        end
    end

    // Output per path
    always_comb begin
        unique case (path)
            PATH_OFF:    out_o = 1'b0;
            PATH_PASS:   out_o = pin_i;
            PATH_INVERT: out_o = ~pin_i;
            PATH_TOGGLE: out_o = pin_i ^ prev_q;
            default:     out_o = 1'b0;
        endcase
    end

    // R8: a transition on a dual-edge pin yields a pulse
    a_r8_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && en_i && (cfg_i == TYPE_BOTH) && (pin_i != $past(pin_i))) |-> out_o);

    // R8: a stable dual-edge pin stays quiet
    a_r8_quiet_when_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && en_i && (cfg_i == TYPE_BOTH) && $stable(pin_i)) |-> !out_o);

endmodule

// File: rtl/wake_irq_conv.sv
module wake_irq_conv
    import wic_pkg::*;
#(
    parameter int NUM_PINS = 126,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out
);

    logic [NUM_PINS-1:0]      en_vec;
    logic [NUM_PINS-1:0][2:0] cfg_vec;

    wic_regfile #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_o      (en_vec),
        .cfg_o     (cfg_vec)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        wic_pin_cond u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (en_vec[g]),
            .cfg_i (cfg_vec[g]),
            .pin_i (pin_in[g]),
            .out_o (pin_out[g])
        );
    end

    // R5: no disabled pin ever drives high
    a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~en_vec) == '0));

endmodule

// File: tb/wake_irq_conv_tb_top.sv
module wake_irq_conv_tb_top;

    localparam int NP = 126;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr;
    logic          reg_we;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;

    always #5 clk = ~clk;

    wake_irq_conv #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    typedef struct {
        bit            is_rd;
        logic [NP-1:0] exp;
        logic [NP-1:0] mask;
        string         req;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;

    // Requirement model
    logic [NP-1:0] en_m;
    logic [2:0]    cfg_m [NP];
    logic [NP-1:0] prev_m = '0;

    always @(posedge clk) prev_m <= pin_in;

    function automatic logic [NP-1:0] mdl(input logic [NP-1:0] pv);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            if (!en_m[p])             r[p] = 1'b0;
            else if (cfg_m[p] == 3'd7) r[p] = pv[p] ^ prev_m[p];
            else if (cfg_m[p][2])      r[p] = pv[p];
            else                       r[p] = ~pv[p];
        end
        return r;
    endfunction

    function automatic logic [NP-1:0] mask_of(input logic [2:0] a, input logic [2:0] b);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = en_m[p] && (cfg_m[p] == a || cfg_m[p] == b);
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
        logic [31:0] r = '0;
        int w;
        if (a[1:0] == 2'b00 && a >= 12'h010 && a < 12'h020) begin
            w = int'(a - 12'h010) / 4;
            for (int b = 0; b < 32; b++) if (w * 32 + b < NP) r[b] = en_m[w * 32 + b];
        end else if (a[1:0] == 2'b00 && a >= 12'h110 && a < 12'h110 + 4 * NP) begin
            r[2:0] = cfg_m[int'(a - 12'h110) / 4];
        end
        return r;
    endfunction

    task automatic mdl_wr(input logic [AW-1:0] a, input logic [31:0] d);
        int w;
        if (a[1:0] == 2'b00 && a >= 12'h010 && a < 12'h020) begin
            w = int'(a - 12'h010) / 4;
            for (int b = 0; b < 32; b++) if (w * 32 + b < NP) en_m[w * 32 + b] = d[b];
        end else if (a[1:0] == 2'b00 && a >= 12'h110 && a < 12'h110 + 4 * NP) begin
            cfg_m[int'(a - 12'h110) / 4] = d[2:0];
        end
    endtask

    // Driver: one cycle of stimulus, optional write, optional output check
    task automatic cyc(input logic [NP-1:0] pv, input bit we, input logic [AW-1:0] a,
                       input logic [31:0] d, input bit chk, input string req,
                       input logic [NP-1:0] msk);
        item_t it;
        pin_in = pv; reg_we = we; reg_addr = a; reg_wdata = d;
        if (chk) begin
            it.is_rd = 1'b0; it.exp = mdl(pv); it.mask = msk; it.req = req;
            q.push_back(it);
        end
        @(posedge clk); #1;
        if (we) mdl_wr(a, d);
        reg_we = 1'b0;
    endtask

    // Driver: read check, optionally with a write to the same address
    task automatic rdc(input logic [AW-1:0] a, input bit we, input logic [31:0] d,
                       input string req);
        item_t it;
        reg_addr = a; reg_we = we; reg_wdata = d;
        it.is_rd = 1'b1; it.exp = NP'(exp_rd(a)); it.mask = '1; it.req = req;
        q.push_back(it);
        @(posedge clk); #1;
        if (we) mdl_wr(a, d);
        reg_we = 1'b0;
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (it.is_rd) begin
                    if (reg_rdata !== it.exp[31:0]) begin
                        bad++;
                        $display("FAIL %s: rdata=%h expected %h", it.req, reg_rdata, it.exp[31:0]);
                    end
                end else if ((pin_out & it.mask) !== (it.exp & it.mask)) begin
                    bad++;
                    $display("FAIL %s: pin_out=%h expected %h", it.req,
                             pin_out & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NP-1:0] pats [8];
        logic [NP-1:0] cur;
        logic [2:0] codes [5];
        codes[0] = 3'd0; codes[1] = 3'd2; codes[2] = 3'd4; codes[3] = 3'd6; codes[4] = 3'd7;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pin_in = '0;
        en_m = '0;
        for (int p = 0; p < NP; p++) cfg_m[p] = 3'd4;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        cyc('0, 0, '0, '0, 1, "R1", '1);
        cyc('1, 0, '0, '0, 1, "R1", '1);
        rdc(12'h010, 0, '0, "R1");
        rdc(12'h01C, 0, '0, "R1");
        rdc(12'h110 + 12'd20, 0, '0, "R1");
        cyc('0, 0, '0, '0, 0, "", '0);

        // R2 enable banks
        for (int w = 0; w < 4; w++) cyc('0, 1, AW'(12'h010 + 4 * w), 32'hFFFF_FFFF, 0, "", '0);
        rdc(12'h01C, 0, '0, "R2");
        rdc(12'h010, 0, '0, "R2");

        // R3 type words
        for (int p = 0; p < NP; p++)
            cyc('0, 1, AW'(12'h110 + 4 * p), {29'd0, codes[p % 5]}, 0, "", '0);
        rdc(AW'(12'h110 + 4 * 125), 0, '0, "R3");
        cyc('0, 1, AW'(12'h110 + 4 * 3), 32'hABCD_EF06, 0, "", '0);
        rdc(AW'(12'h110 + 4 * 3), 0, '0, "R3");
        rdc(AW'(12'h110 + 4 * 4), 0, '0, "R3");

        // R6 R7 R8 over several patterns
        pats[0] = '0; pats[1] = '1;
        for (int p = 0; p < NP; p++) begin pats[2][p] = p[0]; pats[3][p] = ~p[0]; end
        for (int k = 4; k < 8; k++) pats[k] = NP'({$urandom, $urandom, $urandom, $urandom});
        for (int k = 0; k < 8; k++) begin
            cyc(pats[k], 0, '0, '0, 1, "R8", mask_of(3'd7, 3'd7));
            cyc(pats[k], 0, '0, '0, 1, "R6", mask_of(3'd4, 3'd6));
            cyc(pats[k], 0, '0, '0, 1, "R7", mask_of(3'd0, 3'd2));
            cyc(pats[k], 0, '0, '0, 1, "R8", mask_of(3'd7, 3'd7));
        end

        // R5 disabled pins
        cyc(pin_in, 1, 12'h014, 32'h0, 0, "", '0);
        cyc(pin_in, 1, 12'h018, 32'h0000_FFFF, 0, "", '0);
        rdc(12'h018, 0, '0, "R2");
        cyc('1, 0, '0, '0, 1, "R5", ~en_m);
        cyc('0, 0, '0, '0, 1, "R5", ~en_m);
        cyc(pats[5], 0, '0, '0, 1, "R5", '1);

        // R4 unmapped accesses
        rdc(12'h000, 0, '0, "R4");
        rdc(12'h020, 0, '0, "R4");
        rdc(12'h111, 0, '0, "R4");
        rdc(AW'(12'h110 + 4 * NP), 0, '0, "R4");
        rdc(12'hFFC, 0, '0, "R4");
        cur = pin_in;
        cyc(cur, 1, 12'h020, 32'hFFFF_FFFF, 0, "", '0);
        cyc(cur, 1, 12'h112, 32'h0000_0004, 0, "", '0);
        cyc(cur, 1, AW'(12'h110 + 4 * NP), 32'hFFFF_FFFF, 0, "", '0);
        cyc(cur, 1, 12'h00C, 32'hFFFF_FFFF, 0, "", '0);
        rdc(12'h110, 0, '0, "R4");
        rdc(12'h014, 0, '0, "R4");
        cyc(cur, 0, '0, '0, 1, "R4", '1);

        // R9 write in the same cycle as a pin change
        cur = pin_in; cur[4] = 1'b1; cur[0] = 1'b0;
        cyc(cur, 0, '0, '0, 0, "", '0);
        cyc(cur, 0, '0, '0, 0, "", '0);
        cur[4] = 1'b0;
        cyc(cur, 1, AW'(12'h110 + 4 * 4), 32'd4, 1, "R9", NP'(1) << 4);
        cyc(cur, 0, '0, '0, 1, "R9", NP'(1) << 4);
        cyc(cur, 1, 12'h010, 32'hFFFF_FFFE, 1, "R9", NP'(1));
        cyc(cur, 0, '0, '0, 1, "R9", NP'(1));
        rdc(AW'(12'h110 + 4 * 2), 1, 32'd2, "R9");
        rdc(AW'(12'h110 + 4 * 2), 0, '0, "R9");

        @(negedge clk);
        @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule